// File: doc/BRIEF.md
# Sequencer Run and Trigger Control

This block decides, cycle by cycle, whether the clock-pattern sequencer is allowed to fetch and execute dispatch entries. It watches a start, a graceful stop and an abort command, a mode bit, two external trigger lines, and indications from the program stream: a synchronisation marker, an end-of-program flag and an entry-complete flag. It also watches the FIFO-empty status from the sequencer. It drives a single go/hold output, an idle flag and the active mode.

In free-running mode the sequencer runs as soon as start arrives. In external trigger mode it first waits for a rising edge on trigger A. After that it holds at every synchronisation marker and at the end of the program until a rising edge on trigger B. A graceful stop waits until the dispatch entry in flight has been fully handed over. An abort stops at once. Both then wait for the FIFO to run empty before the block reports idle.

Top module: `seq_runctl`

## Requirements
- R1: After reset the block is idle (`idle_o`=1), `go_o` is 0 and `mode_o` is 0.
- R2: With `mode_i`=0 (free-running), a start seen while idle raises `go_o` on the next clock edge.
- R3: With `mode_i`=1 (trigger mode), a start leaves `go_o` low until a rising edge on `trig_a_i`. `go_o` rises on exactly the SYNC_STAGES+1-th clock edge after `trig_a_i` goes high.
- R4: In trigger mode, `sync_mark_i` while running drops `go_o` on the next edge. Execution resumes only after a rising edge on `trig_b_i`. In free-running mode `sync_mark_i` has no effect on `go_o`.
- R5: `prog_end_i` while running ends execution. In free-running mode the block goes straight to draining. In trigger mode it holds with `go_o`=0 until a `trig_b_i` rising edge, and only then drains.
- R6: A stop while running keeps `go_o` high until `entry_done_i` marks the end of the current dispatch entry. `go_o` drops on the edge after that.
- R7: `abort_i` in any active state drops `go_o` on the next clock edge, without waiting for an entry boundary.
- R8: After a stop, an abort or the end of the program, `idle_o` stays 0 while `fifo_empty_i` is 0. It rises on the edge after `fifo_empty_i` is seen at 1.
- R9: Trigger edges that arrive while the block is not waiting for that trigger are dropped, not stored. This covers `trig_b_i` while armed or running, and any trigger while idle.
- R10: A start while the block is active is ignored. `mode_o` follows `mode_i` only while idle and stays frozen otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Graceful stop at the next entry boundary |
| abort_i | input | 1 | Immediate stop |
| mode_i | input | 1 | 0 free-running, 1 external trigger |
| trig_a_i | input | 1 | Asynchronous trigger that begins execution |
| trig_b_i | input | 1 | Asynchronous trigger that resumes from a sync point |
| sync_mark_i | input | 1 | Synchronisation marker from the program stream |
| prog_end_i | input | 1 | Program loop has completed |
| entry_done_i | input | 1 | Current dispatch entry fully transferred |
| fifo_empty_i | input | 1 | Sequencer FIFO is empty |
| go_o | output | 1 | 1 lets the sequencer fetch and execute |
| idle_o | output | 1 | Block is stopped and FIFO drained |
| mode_o | output | 1 | Mode in effect |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This makes the exact trigger-to-go latency check depend on the parameter and not on a fixed constant. Wait windows after each ignored trigger are longer than the deeper chain, so a trigger that was wrongly stored would have time to show up on `go_o` before the next stimulus.

// File: rtl/seq_runctl_pkg.sv
package seq_runctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_HOLD,
    ST_FINISH,
    ST_ENDWAIT,
    ST_DRAIN
  } run_state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/seq_trig_edge.sv
module seq_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], raw_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R9: an edge is a single-cycle event, never a level that could be reused
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/seq_runctl_fsm.sv
module seq_runctl_fsm
  import seq_runctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic abort_i,
  input  logic mode_i,
  input  logic rise_a_i,
  input  logic rise_b_i,
  input  logic sync_mark_i,
  input  logic prog_end_i,
  input  logic entry_done_i,
  input  logic fifo_empty_i,
  output logic go_o,
  output logic idle_o,
  output logic mode_o
);
  run_state_e st_q, st_d;
  logic       mode_q;
  logic       mode_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) st_d = mode_i ? ST_ARM : ST_RUN;
      end
      ST_ARM: begin
        if (abort_i || stop_i) st_d = ST_DRAIN;
        else if (rise_a_i)     st_d = ST_RUN;
      end
      ST_RUN: begin
        if (abort_i)                  st_d = ST_DRAIN;
        else if (prog_end_i)          st_d = mode_q ? ST_ENDWAIT : ST_DRAIN;
        else if (stop_i)              st_d = entry_done_i ? ST_DRAIN : ST_FINISH;
        else if (sync_mark_i && mode_q) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (abort_i || stop_i) st_d = ST_DRAIN;
        else if (rise_b_i)     st_d = ST_RUN;
      end
      ST_FINISH: begin
        if (abort_i || entry_done_i || prog_end_i) st_d = ST_DRAIN;
      end
      ST_ENDWAIT: begin
        if (abort_i || stop_i || rise_b_i) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (fifo_empty_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign mode_en = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_i;
  end

  assign go_o   = (st_q == ST_RUN) || (st_q == ST_FINISH);
  assign idle_o = (st_q == ST_IDLE);
  assign mode_o = mode_q;

  // R2: free-running start reaches go in one edge
  a_r2_start_go: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && start_i && !mode_i) |=> go_o);

  // R6: a pending stop keeps the entry running until its boundary
  a_r6_finish_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINISH && !entry_done_i && !abort_i && !prog_end_i) |=> go_o);

  // R7: abort removes go on the next edge
  a_r7_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && abort_i) |=> !go_o);

  // R8: idle is only reached with an empty FIFO
  a_r8_idle_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(fifo_empty_i));

  // R10: mode frozen while active
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_o |=> $stable(mode_o));
endmodule

// File: rtl/seq_runctl.sv
module seq_runctl #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic abort_i,
  input  logic mode_i,
  input  logic trig_a_i,
  input  logic trig_b_i,
  input  logic sync_mark_i,
  input  logic prog_end_i,
  input  logic entry_done_i,
  input  logic fifo_empty_i,
  output logic go_o,
  output logic idle_o,
  output logic mode_o
);
  localparam int NTRIG = 2;

  logic             rst_n_s;
  logic [NTRIG-1:0] trig_raw;
  logic [NTRIG-1:0] trig_rise;

  assign trig_raw = {trig_b_i, trig_a_i};

  seq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_n_o(rst_n_s)
  );

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    seq_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n_s),
      .raw_i (trig_raw[g]),
      .rise_o(trig_rise[g])
    );
  end

  seq_runctl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .abort_i     (abort_i),
    .mode_i      (mode_i),
    .rise_a_i    (trig_rise[0]),
    .rise_b_i    (trig_rise[1]),
    .sync_mark_i (sync_mark_i),
    .prog_end_i  (prog_end_i),
    .entry_done_i(entry_done_i),
    .fifo_empty_i(fifo_empty_i),
    .go_o        (go_o),
    .idle_o      (idle_o),
    .mode_o      (mode_o)
  );
endmodule

// File: tb/seq_runctl_tb_top.sv
module seq_runctl_tb_top;
  localparam int SYNC = 3;
  localparam int SETTLE = SYNC + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, abort_i = 0, mode_i = 0;
  logic trig_a_i = 0, trig_b_i = 0, sync_mark_i = 0, prog_end_i = 0;
  logic entry_done_i = 0, fifo_empty_i = 1;
  logic go_o, idle_o, mode_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seq_runctl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .abort_i(abort_i), .mode_i(mode_i), .trig_a_i(trig_a_i),
    .trig_b_i(trig_b_i), .sync_mark_i(sync_mark_i), .prog_end_i(prog_end_i),
    .entry_done_i(entry_done_i), .fifo_empty_i(fifo_empty_i),
    .go_o(go_o), .idle_o(idle_o), .mode_o(mode_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle pulse on a command line, then back at the next negedge
  task automatic pulse_start();  start_i = 1; cyc(1); start_i = 0; endtask
  task automatic pulse_stop();   stop_i = 1; cyc(1); stop_i = 0; endtask
  task automatic pulse_abort();  abort_i = 1; cyc(1); abort_i = 0; endtask
  task automatic pulse_sync();   sync_mark_i = 1; cyc(1); sync_mark_i = 0; endtask
  task automatic pulse_end();    prog_end_i = 1; cyc(1); prog_end_i = 0; endtask
  task automatic pulse_done();   entry_done_i = 1; cyc(1); entry_done_i = 0; endtask
  task automatic pulse_b();      trig_b_i = 1; cyc(1); trig_b_i = 0; endtask

  task automatic t_reset();
    chk("R1", "idle after reset", idle_o, 1'b1);
    chk("R1", "go after reset", go_o, 1'b0);
    chk("R1", "mode after reset", mode_o, 1'b0);
  endtask

  task automatic t_free_run();
    mode_i = 0; cyc(1);
    pulse_start();
    chk("R2", "go after start", go_o, 1'b1);
    chk("R2", "not idle", idle_o, 1'b0);
    pulse_sync(); cyc(2);
    chk("R4", "free-run ignores sync mark", go_o, 1'b1);
    fifo_empty_i = 0;
    pulse_end();
    chk("R5", "free-run end drops go", go_o, 1'b0);
    cyc(4);
    chk("R8", "waits for empty fifo", idle_o, 1'b0);
    fifo_empty_i = 1; cyc(1);
    chk("R8", "idle after fifo empty", idle_o, 1'b1);
  endtask

  task automatic t_trigger();
    mode_i = 1; cyc(1);
    pulse_start();
    chk("R3", "armed holds go", go_o, 1'b0);
    pulse_b(); cyc(SETTLE);
    chk("R9", "trig B while armed ignored", go_o, 1'b0);
    trig_a_i = 1;
    cyc(SYNC);
    chk("R3", "go low before sync latency", go_o, 1'b0);
    cyc(1);
    chk("R3", "go after trig A latency", go_o, 1'b1);
    trig_a_i = 0;
    mode_i = 0; cyc(1);
    chk("R10", "mode frozen while active", mode_o, 1'b1);
    pulse_start();
    chk("R10", "start while active ignored", idle_o, 1'b0);
    chk("R10", "still running", go_o, 1'b1);
    pulse_sync();
    chk("R4", "sync mark holds", go_o, 1'b0);
    pulse_b(); cyc(SETTLE);
    chk("R4", "trig B resumes", go_o, 1'b1);
    pulse_b(); cyc(SETTLE);
    pulse_sync(); cyc(SETTLE);
    chk("R9", "trig B during run not stored", go_o, 1'b0);
    pulse_b(); cyc(SETTLE);
    chk("R4", "resume again", go_o, 1'b1);
    pulse_end(); cyc(SETTLE);
    chk("R5", "end waits for trig B: go", go_o, 1'b0);
    chk("R5", "end waits for trig B: idle", idle_o, 1'b0);
    pulse_b(); cyc(SETTLE);
    chk("R5", "idle after trig B at end", idle_o, 1'b1);
    cyc(1);
    chk("R10", "mode follows input when idle", mode_o, 1'b0);
  endtask

  task automatic t_stop();
    mode_i = 0; cyc(1);
    pulse_start();
    pulse_stop(); cyc(3);
    chk("R6", "go kept until entry boundary", go_o, 1'b1);
    pulse_done();
    chk("R6", "go dropped after entry done", go_o, 1'b0);
    cyc(1);
    chk("R8", "idle after stop drain", idle_o, 1'b1);
  endtask

  task automatic t_abort();
    mode_i = 0; cyc(1);
    pulse_start();
    fifo_empty_i = 0;
    pulse_abort();
    chk("R7", "abort drops go at once", go_o, 1'b0);
    cyc(3);
    chk("R8", "abort waits for fifo", idle_o, 1'b0);
    fifo_empty_i = 1; cyc(1);
    chk("R8", "idle after abort drain", idle_o, 1'b1);
    mode_i = 1; cyc(1);
    pulse_start();
    pulse_abort(); cyc(1);
    chk("R7", "abort while armed returns idle", idle_o, 1'b1);
    trig_a_i = 1; cyc(SETTLE); trig_a_i = 0;
    chk("R9", "trig A while idle ignored", go_o, 1'b0);
    mode_i = 0; cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(5);
    t_reset();
    t_free_run();
    t_trigger();
    t_stop();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule